// File: doc/BRIEF.md
# Simultaneous Sampling Conversion Sequencer

This block is the control side of a sampling front end in which one pair of converters serves three channel pairs, named A, B and C. Every pair has its own active-low hold strobe. A high-to-low transition on a strobe freezes both sample values of that pair at that instant and queues the pair for conversion. Strobing several pairs in the same cycle therefore samples all of their channels together. The pairs are then converted one after another, each in its own fixed-length slot.

The analog conversion is modelled by the sample inputs. Each pair presents two 12-bit values, one for its first channel and one for its second. During each conversion an active-low busy output stays low for a fixed window. When the window ends, the block issues a one-cycle write strobe that carries the pair index and both captured results to a downstream result store.

A strobe that arrives for a pair whose earlier request has not yet been written is dropped, and a sticky overrun flag records the loss. A synchronous reset aborts all work in progress.

Top module: `dual_conv_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears everything. After that edge, `busy_n` is 1, and `wr_en`, `wr_pair`, `wr_x0`, `wr_x1` and `overrun` are 0. No request remains queued.
- R2: A request for pair p is registered only when `hold_n[p]` was 1 at one rising edge and is 0 at the next. Holding `hold_n[p]` low for further cycles produces no further request.
- R3: At the edge that accepts a request, the block captures both sample inputs of that pair. Pair p uses bits [p*12+11:p*12] of `samp_x0` and of `samp_x1`. These captured values are the ones later written. Pairs strobed in the same cycle are all captured at that one edge.
- R4: Suppose the block is idle and a request is accepted at edge k. Then `busy_n` falls after edge k+1 and stays low for exactly 13 cycles.
- R5: At the edge where `busy_n` returns high, `wr_en` is 1 for exactly one cycle. At that same edge, `wr_pair`, `wr_x0` and `wr_x1` change to the converted pair's index and its two captured values, and they hold those values until the next write.
- R6: Queued pairs are converted lowest index first, A before B before C. The index is encoded on `wr_pair` as A=0, B=1, C=2.
- R7: Each conversion occupies a 16-cycle slot. When more requests are queued, consecutive `busy_n` falls, and consecutive `wr_en` pulses, are exactly 16 cycles apart.
- R8: A falling edge for a pair whose earlier request has not yet produced its write strobe is ignored. It adds no conversion and does not change the captured values. It also sets `overrun`, which then stays 1 until reset.
- R9: A reset during a conversion cancels that conversion and all queued requests. No write strobe follows from them.
- R10: If `hold_n[p]` is already low while `rst` is high, that low level is not treated as a falling edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hold_n | input | 3 | Active-low hold strobes, bit 0 = pair A, bit 2 = pair C |
| samp_x0 | input | 36 | First-channel sample per pair, 12 bits per pair, pair A lowest |
| samp_x1 | input | 36 | Second-channel sample per pair, same layout |
| busy_n | output | 1 | Low while a conversion window runs |
| wr_en | output | 1 | One-cycle write strobe to the result store |
| wr_pair | output | 2 | Index of the pair being written |
| wr_x0 | output | 12 | First-channel result |
| wr_x1 | output | 12 | Second-channel result |
| overrun | output | 1 | Sticky flag for a dropped hold strobe |

## Verification
A strobe seen at edge k, with the block idle, pulls `busy_n` low after edge k+1. The write strobe and its data follow after edge k+14, and the next queued conversion starts after edge k+17, exactly 16 cycles after the previous start. The bench drives inputs on the falling clock edge and steps a behavioural model on the rising edge, so every output is compared at mid-cycle in the same cycle in which the design updates it. Directed checks then count the write strobes in each phase, and measure the spacing between the last two writes, to confirm the ordering, the ignored strobes and the reset cases.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_RUN  = 1'b1
  } slot_state_e;
endpackage

// File: rtl/dcs_hold_capture.sv
module dcs_hold_capture #(
  parameter int unsigned PAIRS  = 3,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PAIRS-1:0]         hold_n,
  input  logic [PAIRS*DATA_W-1:0]  samp_x0,
  input  logic [PAIRS*DATA_W-1:0]  samp_x1,
  input  logic                     clr_vld,
  input  logic [IDX_W-1:0]         clr_idx,
  output logic [PAIRS-1:0]         pend,
  output logic [PAIRS*DATA_W-1:0]  held_x0,
  output logic [PAIRS*DATA_W-1:0]  held_x1,
  output logic                     overrun
);

  logic [PAIRS-1:0]        hold_q;
  logic [PAIRS-1:0]        fall;
  logic [PAIRS-1:0]        pend_q;
  logic [PAIRS*DATA_W-1:0] x0_q;
  logic [PAIRS*DATA_W-1:0] x1_q;
  logic                    ovr_q;

  // Previous strobe level tracks the pins even in reset, so a level held
  // low across reset is not seen as an edge afterwards.
  always_ff @(posedge clk) begin
    hold_q <= hold_n;
  end

  assign fall = hold_q & ~hold_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      x0_q   <= '0;
      x1_q   <= '0;
      ovr_q  <= 1'b0;
    end else begin
      for (int i = 0; i < PAIRS; i++) begin
        if (clr_vld && (clr_idx == IDX_W'(i))) begin
          pend_q[i] <= 1'b0;
        end else if (fall[i] && !pend_q[i]) begin
          pend_q[i]                  <= 1'b1;
          x0_q[i*DATA_W +: DATA_W]   <= samp_x0[i*DATA_W +: DATA_W];
          x1_q[i*DATA_W +: DATA_W]   <= samp_x1[i*DATA_W +: DATA_W];
        end
      end
      if (|(fall & pend_q)) begin
        ovr_q <= 1'b1;
      end
    end
  end

  assign pend    = pend_q;
  assign held_x0 = x0_q;
  assign held_x1 = x1_q;
  assign overrun = ovr_q;

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> ovr_q);

  assert_clear_only_pending_R5: assert property (@(posedge clk) disable iff (rst)
    clr_vld |-> pend_q[clr_idx]);

endmodule

// File: rtl/dcs_prio_pick.sv
module dcs_prio_pick #(
  parameter int unsigned PAIRS = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic [PAIRS-1:0] req,
  output logic             pick_vld,
  output logic [IDX_W-1:0] pick_idx
);

  always_comb begin
    pick_vld = |req;
    pick_idx = '0;
    for (int i = PAIRS - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/dcs_slot_ctrl.sv
module dcs_slot_ctrl
  import dcs_pkg::*;
#(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned BUSY_CYC = 13,
  parameter int unsigned SLOT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pick_vld,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic [DATA_W-1:0] sel_x0,
  input  logic [DATA_W-1:0] sel_x1,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              done,
  output logic              busy_n,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_pair,
  output logic [DATA_W-1:0] wr_x0,
  output logic [DATA_W-1:0] wr_x1
);

  localparam int unsigned CNT_W = $clog2(SLOT_CYC);

  slot_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  cur_q;
  logic              busy_n_q;
  logic              wr_q;
  logic [IDX_W-1:0]  pair_q;
  logic [DATA_W-1:0] x0_q;
  logic [DATA_W-1:0] x1_q;
  logic              slot_end;

  assign done     = (state_q == SLOT_RUN) && (cnt_q == CNT_W'(BUSY_CYC - 1));
  assign slot_end = (cnt_q == CNT_W'(SLOT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SLOT_IDLE;
      cnt_q    <= '0;
      cur_q    <= '0;
      busy_n_q <= 1'b1;
      wr_q     <= 1'b0;
      pair_q   <= '0;
      x0_q     <= '0;
      x1_q     <= '0;
    end else begin
      wr_q <= done;
      if (done) begin
        busy_n_q <= 1'b1;
        pair_q   <= cur_q;
        x0_q     <= sel_x0;
        x1_q     <= sel_x1;
      end
      unique case (state_q)
        SLOT_IDLE: begin
          if (pick_vld) begin
            state_q  <= SLOT_RUN;
            cur_q    <= pick_idx;
            cnt_q    <= '0;
            busy_n_q <= 1'b0;
          end
        end
        SLOT_RUN: begin
          if (slot_end) begin
            if (pick_vld) begin
              cur_q    <= pick_idx;
              cnt_q    <= '0;
              busy_n_q <= 1'b0;
            end else begin
              state_q <= SLOT_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign cur_idx = cur_q;
  assign busy_n  = busy_n_q;
  assign wr_en   = wr_q;
  assign wr_pair = pair_q;
  assign wr_x0   = x0_q;
  assign wr_x1   = x1_q;

  // Independent count of busy-low cycles for the window check.
  logic [CNT_W:0] low_run_q;
  always_ff @(posedge clk) begin
    if (rst || busy_n_q) begin
      low_run_q <= '0;
    end else begin
      low_run_q <= low_run_q + 1'b1;
    end
  end

  assert_busy_window_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_n_q) && !$past(rst)) |-> (low_run_q == (CNT_W+1)'(BUSY_CYC)));

  assert_write_on_busy_rise_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_n_q) && !$past(rst)) |-> wr_q);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    wr_q |=> !wr_q);

  assert_busy_only_in_slot_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_n_q |-> (state_q == SLOT_RUN));

endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq #(
  parameter int unsigned PAIRS    = 3,
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned BUSY_CYC = 13,
  parameter int unsigned SLOT_CYC = 16,
  parameter int unsigned IDX_W    = $clog2(PAIRS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PAIRS-1:0]        hold_n,
  input  logic [PAIRS*DATA_W-1:0] samp_x0,
  input  logic [PAIRS*DATA_W-1:0] samp_x1,
  output logic                    busy_n,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_pair,
  output logic [DATA_W-1:0]       wr_x0,
  output logic [DATA_W-1:0]       wr_x1,
  output logic                    overrun
);

  logic [PAIRS-1:0]        pend;
  logic [PAIRS*DATA_W-1:0] held_x0;
  logic [PAIRS*DATA_W-1:0] held_x1;
  logic                    pick_vld;
  logic [IDX_W-1:0]        pick_idx;
  logic [IDX_W-1:0]        cur_idx;
  logic                    done;
  logic [DATA_W-1:0]       sel_x0;
  logic [DATA_W-1:0]       sel_x1;

  dcs_hold_capture #(.PAIRS(PAIRS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .hold_n  (hold_n),
    .samp_x0 (samp_x0),
    .samp_x1 (samp_x1),
    .clr_vld (done),
    .clr_idx (cur_idx),
    .pend    (pend),
    .held_x0 (held_x0),
    .held_x1 (held_x1),
    .overrun (overrun)
  );

  dcs_prio_pick #(.PAIRS(PAIRS), .IDX_W(IDX_W)) u_pick (
    .req      (pend),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  always_comb begin
    sel_x0 = '0;
    sel_x1 = '0;
    for (int i = 0; i < PAIRS; i++) begin
      if (cur_idx == IDX_W'(i)) begin
        sel_x0 = held_x0[i*DATA_W +: DATA_W];
        sel_x1 = held_x1[i*DATA_W +: DATA_W];
      end
    end
  end

  dcs_slot_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BUSY_CYC(BUSY_CYC),
                  .SLOT_CYC(SLOT_CYC)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx),
    .sel_x0   (sel_x0),
    .sel_x1   (sel_x1),
    .cur_idx  (cur_idx),
    .done     (done),
    .busy_n   (busy_n),
    .wr_en    (wr_en),
    .wr_pair  (wr_pair),
    .wr_x0    (wr_x0),
    .wr_x1    (wr_x1)
  );

endmodule

// File: tb/dual_conv_seq_tb.sv
module dual_conv_seq_tb_top;
  localparam int NP   = 3;
  localparam int DW   = 12;
  localparam int BUSY = 13;
  localparam int SLOT = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst;
  logic [NP-1:0]     hold_n;
  logic [NP*DW-1:0]  sx0;
  logic [NP*DW-1:0]  sx1;
  logic              busy_n;
  logic              wr_en;
  logic [1:0]        wr_pair;
  logic [DW-1:0]     wr_x0;
  logic [DW-1:0]     wr_x1;
  logic              overrun;

  dual_conv_seq dut_i (
    .clk(clk), .rst(rst), .hold_n(hold_n), .samp_x0(sx0), .samp_x1(sx1),
    .busy_n(busy_n), .wr_en(wr_en), .wr_pair(wr_pair), .wr_x0(wr_x0),
    .wr_x1(wr_x1), .overrun(overrun)
  );

  int vecs = 0;
  int miss = 0;
  int cyc = 0;
  int wr_total = 0;
  int wr_prev = 0;
  int wr_last = 0;
  bit finished = 1'b0;

  // Behavioural reference model
  bit m_hq[NP];
  bit m_pend[NP];
  int m_s0[NP];
  int m_s1[NP];
  bit m_act = 1'b0;
  int m_cur = 0;
  int m_cnt = 0;
  bit m_busy_n = 1'b1;
  bit m_wr = 1'b0;
  int m_pair = 0;
  int m_x0 = 0;
  int m_x1 = 0;
  bit m_ovr = 1'b0;

  always @(posedge clk) begin : model
    bit done;
    int dp;
    int first;
    bit opend[NP];
    if (rst) begin
      for (int i = 0; i < NP; i++) begin
        m_hq[i] = hold_n[i]; m_pend[i] = 1'b0; m_s0[i] = 0; m_s1[i] = 0;
      end
      m_act = 1'b0; m_cur = 0; m_cnt = 0; m_busy_n = 1'b1; m_wr = 1'b0;
      m_pair = 0; m_x0 = 0; m_x1 = 0; m_ovr = 1'b0;
    end else begin
      done = m_act && (m_cnt == BUSY - 1);
      dp = m_cur;
      for (int i = 0; i < NP; i++) opend[i] = m_pend[i];
      m_wr = done;
      if (done) begin
        m_busy_n = 1'b1; m_pair = dp; m_x0 = m_s0[dp]; m_x1 = m_s1[dp];
      end
      for (int i = 0; i < NP; i++) begin
        if (m_hq[i] && !hold_n[i]) begin
          if (opend[i]) m_ovr = 1'b1;
          else begin
            m_pend[i] = 1'b1;
            m_s0[i] = int'(sx0[i*DW +: DW]);
            m_s1[i] = int'(sx1[i*DW +: DW]);
          end
        end
      end
      if (done) m_pend[dp] = 1'b0;
      first = -1;
      for (int i = NP - 1; i >= 0; i--) if (opend[i]) first = i;
      if (!m_act) begin
        if (first >= 0) begin
          m_act = 1'b1; m_cur = first; m_cnt = 0; m_busy_n = 1'b0;
        end
      end else if (m_cnt == SLOT - 1) begin
        if (first >= 0) begin
          m_cur = first; m_cnt = 0; m_busy_n = 1'b0;
        end else m_act = 1'b0;
      end else m_cnt++;
      for (int i = 0; i < NP; i++) m_hq[i] = hold_n[i];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  // Per-cycle comparison at mid-cycle
  always @(negedge clk) begin
    if (!finished) begin
      cyc++;
      chk(busy_n === m_busy_n, "R4 busy_n", int'(busy_n), int'(m_busy_n));
      chk(wr_en === m_wr, "R5 wr_en", int'(wr_en), int'(m_wr));
      chk(wr_pair === m_pair[1:0], "R6 wr_pair", int'(wr_pair), m_pair);
      chk(wr_x0 === m_x0[DW-1:0], "R3 wr_x0", int'(wr_x0), m_x0);
      chk(wr_x1 === m_x1[DW-1:0], "R3 wr_x1", int'(wr_x1), m_x1);
      chk(overrun === m_ovr, "R8 overrun", int'(overrun), int'(m_ovr));
      if (wr_en === 1'b1) begin
        wr_total++; wr_prev = wr_last; wr_last = cyc;
      end
      if (cyc > 20000) begin
        miss++;
        $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
        finish_run();
      end
    end
  end

  // Sample inputs change every cycle so the capture instant matters
  always @(negedge clk) begin
    sx0 = {$urandom, $urandom};
    sx1 = {$urandom, $urandom};
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [NP-1:0] m);
    @(negedge clk);
    hold_n = hold_n & ~m;
    wait_cyc(2);
    hold_n = hold_n | m;
  endtask

  initial begin : stim
    int base;
    rst = 1'b1; hold_n = '1;
    wait_cyc(3);
    chk(busy_n === 1'b1, "R1 busy_n after reset", int'(busy_n), 1);
    chk(wr_en === 1'b0, "R1 wr_en after reset", int'(wr_en), 0);
    chk(overrun === 1'b0, "R1 overrun after reset", int'(overrun), 0);
    chk(wr_x0 === '0 && wr_x1 === '0, "R1 data after reset", int'(wr_x0), 0);
    rst = 1'b0;
    wait_cyc(2);

    base = wr_total;
    strobe(3'b010);
    wait_cyc(25);
    chk(wr_total - base == 1, "R2 single strobe writes", wr_total - base, 1);

    base = wr_total;
    strobe(3'b111);
    wait_cyc(60);
    chk(wr_total - base == 3, "R3 joint strobe writes", wr_total - base, 3);
    chk(wr_last - wr_prev == SLOT, "R7 write spacing", wr_last - wr_prev, SLOT);

    base = wr_total;
    strobe(3'b100);
    strobe(3'b010);
    strobe(3'b001);
    wait_cyc(70);
    chk(wr_total - base == 3, "R6 staggered strobes write", wr_total - base, 3);

    base = wr_total;
    strobe(3'b001);
    wait_cyc(3);
    strobe(3'b001);
    wait_cyc(30);
    chk(overrun === 1'b1, "R8 overrun set", int'(overrun), 1);
    chk(wr_total - base == 1, "R8 dropped strobe adds nothing", wr_total - base, 1);

    base = wr_total;
    @(negedge clk);
    hold_n[1] = 1'b0;
    wait_cyc(50);
    hold_n[1] = 1'b1;
    wait_cyc(2);
    chk(wr_total - base == 1, "R2 held level one write", wr_total - base, 1);

    strobe(3'b100);
    wait_cyc(4);
    base = wr_total;
    rst = 1'b1; hold_n[0] = 1'b0;
    wait_cyc(2);
    rst = 1'b0;
    wait_cyc(40);
    chk(wr_total - base == 0, "R9 aborted conversion", wr_total - base, 0);
    chk(busy_n === 1'b1, "R9 busy_n idle", int'(busy_n), 1);
    chk(overrun === 1'b0, "R9 overrun cleared", int'(overrun), 0);
    chk(wr_total - base == 0, "R10 level low across reset", wr_total - base, 0);
    hold_n[0] = 1'b1;
    wait_cyc(2);

    base = wr_total;
    strobe(3'b101);
    wait_cyc(45);
    chk(wr_total - base == 2, "R6 pairs after reset", wr_total - base, 2);
    chk(wr_pair === 2'd2, "R6 last pair index", int'(wr_pair), 2);

    finish_run();
  end

endmodule